// File: doc/BRIEF.md
# Dual-Bus Register-Transfer Datapath

This block executes one register-transfer micro-operation on every clock edge. It has four general registers. Two read selectors place register contents on two internal buses: the operand bus and the second-operand bus. The second-operand bus can carry either a register or an external constant. A function unit computes a result from the buses, using either an arithmetic/logic unit or a single-position shifter. A write-back selector then stores either that result or an external data word into one register. A decoder picks the register, and it loads only when the load enable is set.

The control word comes each cycle from an external driver, such as a micro-sequencer. Both buses are brought out continuously: the operand bus as an address output and the second-operand bus as a data output. Overflow, carry, sign and zero status bits describe the current function result. A complete addition such as R0 := R1 + R2 takes exactly one clock edge.

The reset input clears the registers asynchronously. Its release reaches the registers two clock edges later, through a synchronizer.

Top module: `rt_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers read as zero on `addr_out`. This holds at start-up and when reset is asserted in the middle of operation.
- R2: On a rising clock edge, register k loads the write-back value only when `ld_en` is 1 and `dst_sel` equals k. Every other register, and every register when `ld_en` is 0, keeps its value.
- R3: `addr_out` always shows the register chosen by `a_sel`. `data_out` shows the register chosen by `b_sel` when `cb_sel` is 0, and shows `const_in` when `cb_sel` is 1. Both outputs are combinational.
- R4: With `fu_sel` = 0, the function result is chosen by `alu_op`: 0000 passes bus A, 0001 gives A+1, 0010 gives A+B, 0011 gives A-B, 0100 gives A AND B, 0101 gives A OR B, 0110 gives A XOR B, and 0111 gives NOT A. All results are modulo 2^WIDTH.
- R5: `flag_c` is the carry out of the adder for codes 0001, 0010 and 0011 (for subtraction, 1 means no borrow). `flag_v` is two's-complement overflow for the same codes. Both flags are 0 for every other code and whenever the shifter is selected.
- R6: With `fu_sel` = 1, the function result is bus B shifted according to `sh_op`. Code 01 shifts right by one, code 10 shifts left by one, and both fill with zero. Codes 00 and 11 pass bus B unchanged.
- R7: `flag_n` equals the most significant bit of the function result. `flag_z` is 1 exactly when the function result is all zeros.
- R8: `wb_sel` = 0 writes the function result back. `wb_sel` = 1 writes `ext_din` back, whatever the function unit computes.
- R9: The control word a_sel=01, b_sel=10, cb_sel=0, alu_op=0010, fu_sel=0, wb_sel=0, dst_sel=00, ld_en=1 leaves R1+R2 in R0 after a single clock edge.
- R10: The ALU codes 1000 to 1111 produce an all-zero result with `flag_c` and `flag_v` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_en | input | 1 | Global load enable for the destination register |
| dst_sel | input | 2 | Destination register index |
| a_sel | input | 2 | Register placed on bus A |
| b_sel | input | 2 | Register offered to bus B |
| cb_sel | input | 1 | 0: register onto bus B, 1: constant onto bus B |
| const_in | input | WIDTH | External constant operand |
| alu_op | input | 4 | ALU operation code |
| sh_op | input | 2 | Shifter operation code |
| fu_sel | input | 1 | 0: ALU result, 1: shifter result |
| wb_sel | input | 1 | 0: function result, 1: ext_din written back |
| ext_din | input | WIDTH | External write-back data |
| addr_out | output | WIDTH | Bus A value |
| data_out | output | WIDTH | Bus B value |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Sign of function result |
| flag_z | output | 1 | Function result is zero |

## Verification
The assertions check some behaviours on every cycle. Registers keep their contents when nothing loads. An external word written back appears on the address output once selected. The two bus outputs agree whenever they select the same register. Carry and overflow stay clear for the shifter and the logic codes, and zero and negative are never raised together. Only the bench's scenarios can show the arithmetic and shift values themselves, the exact flag values at wrap-around and signed-overflow boundaries, the one-edge R0 := R1 + R2 word, and the clearing of registers by a reset asserted in the middle of operation.

// File: rtl/rt_dp_pkg.sv
package rt_dp_pkg;

  localparam int unsigned OP_W = 4;
  localparam int unsigned SH_W = 2;

  typedef enum logic [OP_W-1:0] {
    ALU_PASS = 4'b0000,
    ALU_INC  = 4'b0001,
    ALU_ADD  = 4'b0010,
    ALU_SUB  = 4'b0011,
    ALU_AND  = 4'b0100,
    ALU_OR   = 4'b0101,
    ALU_XOR  = 4'b0110,
    ALU_NOT  = 4'b0111
  } alu_op_e;

  typedef enum logic [SH_W-1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_HOLD  = 2'b11
  } sh_op_e;

  function automatic logic is_arith(input logic [OP_W-1:0] op);
    return (op == ALU_INC) || (op == ALU_ADD) || (op == ALU_SUB);
  endfunction

endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rt_regbank.sv
module rt_regbank #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NREG  = 4,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [SEL_W-1:0] a_sel,
  input  logic [SEL_W-1:0] b_sel,
  output logic [WIDTH-1:0] a_data,
  output logic [WIDTH-1:0] b_data
);

  logic [NREG-1:0]  ld_strobe;
  logic [WIDTH-1:0] reg_q   [NREG];
  logic [WIDTH-1:0] reg_nxt [NREG];

  // Destination decoder and per-register next-state logic
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign ld_strobe[k] = ld_en && (dst_sel == SEL_W'(k));

    always_comb begin
      reg_nxt[k] = ld_strobe[k] ? wr_data : reg_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        reg_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NREG; k++) begin
        reg_q[k] <= reg_nxt[k];
      end
    end
  end

  // Read-port selectors
  always_comb begin
    a_data = reg_q[a_sel];
    b_data = reg_q[b_sel];
  end

endmodule

// File: rtl/rt_alu.sv
module rt_alu
  import rt_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             ovf
);

  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_cin;
  logic [WIDTH:0]   add_sum;

  // Shared adder operand steering
  always_comb begin
    add_x   = op_a;
    add_y   = '0;
    add_cin = 1'b0;
    case (op_sel)
      ALU_INC: begin add_y = '0;    add_cin = 1'b1; end
      ALU_ADD: begin add_y = op_b;  add_cin = 1'b0; end
      ALU_SUB: begin add_y = ~op_b; add_cin = 1'b1; end
      default: begin add_y = '0;    add_cin = 1'b0; end
    endcase
  end

  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};

  always_comb begin
    case (op_sel)
      ALU_PASS: result = op_a;
      ALU_INC,
      ALU_ADD,
      ALU_SUB:  result = add_sum[WIDTH-1:0];
      ALU_AND:  result = op_a & op_b;
      ALU_OR:   result = op_a | op_b;
      ALU_XOR:  result = op_a ^ op_b;
      ALU_NOT:  result = ~op_a;
      default:  result = '0;
    endcase
  end

  always_comb begin
    if (is_arith(op_sel)) begin
      carry = add_sum[WIDTH];
      ovf   = (add_x[WIDTH-1] == add_y[WIDTH-1]) &&
              (add_sum[WIDTH-1] != add_x[WIDTH-1]);
    end else begin
      carry = 1'b0;
      ovf   = 1'b0;
    end
  end

endmodule

// File: rtl/rt_shifter.sv
module rt_shifter
  import rt_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] sh_in,
  input  logic [SH_W-1:0]  sh_sel,
  output logic [WIDTH-1:0] sh_out
);

  always_comb begin
    case (sh_sel)
      SH_RIGHT: sh_out = {1'b0, sh_in[WIDTH-1:1]};
      SH_LEFT:  sh_out = {sh_in[WIDTH-2:0], 1'b0};
      default:  sh_out = sh_in;
    endcase
  end

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NREG  = 4,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic [SEL_W-1:0] a_sel,
  input  logic [SEL_W-1:0] b_sel,
  input  logic             cb_sel,
  input  logic [WIDTH-1:0] const_in,
  input  logic [OP_W-1:0]  alu_op,
  input  logic [SH_W-1:0]  sh_op,
  input  logic             fu_sel,
  input  logic             wb_sel,
  input  logic [WIDTH-1:0] ext_din,
  output logic [WIDTH-1:0] addr_out,
  output logic [WIDTH-1:0] data_out,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_z
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] bus_a;
  logic [WIDTH-1:0] reg_b;
  logic [WIDTH-1:0] bus_b;
  logic [WIDTH-1:0] alu_res;
  logic             alu_c;
  logic             alu_v;
  logic [WIDTH-1:0] sh_res;
  logic [WIDTH-1:0] fu_res;
  logic [WIDTH-1:0] wb_data;

  rt_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rt_regbank #(.WIDTH(WIDTH), .NREG(NREG)) i_regbank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (ld_en),
    .dst_sel (dst_sel),
    .wr_data (wb_data),
    .a_sel   (a_sel),
    .b_sel   (b_sel),
    .a_data  (bus_a),
    .b_data  (reg_b)
  );

  // Constant injection onto bus B
  always_comb begin
    bus_b = cb_sel ? const_in : reg_b;
  end

  rt_alu #(.WIDTH(WIDTH)) i_alu (
    .op_a   (bus_a),
    .op_b   (bus_b),
    .op_sel (alu_op),
    .result (alu_res),
    .carry  (alu_c),
    .ovf    (alu_v)
  );

  rt_shifter #(.WIDTH(WIDTH)) i_shifter (
    .sh_in  (bus_b),
    .sh_sel (sh_op),
    .sh_out (sh_res)
  );

  // Function-unit output select, status, and write-back select
  always_comb begin
    fu_res  = fu_sel ? sh_res : alu_res;
    wb_data = wb_sel ? ext_din : fu_res;
  end

  always_comb begin
    flag_c = alu_c && !fu_sel;
    flag_v = alu_v && !fu_sel;
    flag_n = fu_res[WIDTH-1];
    flag_z = (fu_res == '0);
  end

  assign addr_out = bus_a;
  assign data_out = bus_b;

endmodule

// File: rtl/rt_datapath_chk.sv
module rt_datapath_chk
  import rt_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic [SEL_W-1:0] dst_sel,
  input logic [SEL_W-1:0] a_sel,
  input logic [SEL_W-1:0] b_sel,
  input logic             cb_sel,
  input logic [OP_W-1:0]  alu_op,
  input logic             fu_sel,
  input logic             wb_sel,
  input logic [WIDTH-1:0] ext_din,
  input logic [WIDTH-1:0] addr_out,
  input logic [WIDTH-1:0] data_out,
  input logic             flag_v,
  input logic             flag_c,
  input logic             flag_n,
  input logic             flag_z
);

  // R2: an external word written last edge is visible when its register is selected
  assert_ext_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_en) && $past(wb_sel) && (a_sel == $past(dst_sel)))
      |-> (addr_out == $past(ext_din)));

  // R2: without a load, a held selection shows a held value
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_en) && $stable(a_sel)) |-> $stable(addr_out));

  // R3: both buses agree when they read the same register
  assert_bus_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_sel == b_sel) && !cb_sel) |-> (addr_out == data_out));

  // R5: shifter path never raises carry or overflow
  assert_shift_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fu_sel |-> (!flag_c && !flag_v));

  // R5 and R10: non-arithmetic codes keep carry and overflow low
  assert_logic_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fu_sel && !is_arith(alu_op)) |-> (!flag_c && !flag_v));

  // R7: zero and negative are mutually exclusive
  assert_zero_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

endmodule

bind rt_datapath rt_datapath_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_en    (ld_en),
  .dst_sel  (dst_sel),
  .a_sel    (a_sel),
  .b_sel    (b_sel),
  .cb_sel   (cb_sel),
  .alu_op   (alu_op),
  .fu_sel   (fu_sel),
  .wb_sel   (wb_sel),
  .ext_din  (ext_din),
  .addr_out (addr_out),
  .data_out (data_out),
  .flag_v   (flag_v),
  .flag_c   (flag_c),
  .flag_n   (flag_n),
  .flag_z   (flag_z)
);

// File: tb/test_rt_datapath.sv
`timescale 1ns/1ps
module test_rt_datapath;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         ld_en;
  logic [1:0]   dst_sel;
  logic [1:0]   a_sel;
  logic [1:0]   b_sel;
  logic         cb_sel;
  logic [W-1:0] const_in;
  logic [3:0]   alu_op;
  logic [1:0]   sh_op;
  logic         fu_sel;
  logic         wb_sel;
  logic [W-1:0] ext_din;
  logic [W-1:0] addr_out;
  logic [W-1:0] data_out;
  logic         flag_v;
  logic         flag_c;
  logic         flag_n;
  logic         flag_z;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rt_datapath #(.WIDTH(W), .NREG(4)) i_rt_datapath (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .dst_sel(dst_sel),
    .a_sel(a_sel), .b_sel(b_sel), .cb_sel(cb_sel), .const_in(const_in),
    .alu_op(alu_op), .sh_op(sh_op), .fu_sel(fu_sel), .wb_sel(wb_sel),
    .ext_din(ext_din), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {alu_op, fu_sel, sh_op, A, B, result, c, v, n, z}
  localparam int NVEC = 17;
  localparam logic [34:0] VEC [NVEC] = '{
    {4'b0010, 1'b0, 2'b00, 8'h12, 8'h34, 8'h46, 4'b0000},
    {4'b0010, 1'b0, 2'b00, 8'hFF, 8'h01, 8'h00, 4'b1001},
    {4'b0010, 1'b0, 2'b00, 8'h7F, 8'h01, 8'h80, 4'b0110},
    {4'b0011, 1'b0, 2'b00, 8'h50, 8'h20, 8'h30, 4'b1000},
    {4'b0011, 1'b0, 2'b00, 8'h20, 8'h50, 8'hD0, 4'b0010},
    {4'b0011, 1'b0, 2'b00, 8'h80, 8'h01, 8'h7F, 4'b1100},
    {4'b0001, 1'b0, 2'b00, 8'hFF, 8'h00, 8'h00, 4'b1001},
    {4'b0100, 1'b0, 2'b00, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {4'b0101, 1'b0, 2'b00, 8'hF0, 8'h0F, 8'hFF, 4'b0010},
    {4'b0110, 1'b0, 2'b00, 8'hAA, 8'hAA, 8'h00, 4'b0001},
    {4'b0111, 1'b0, 2'b00, 8'h0F, 8'h00, 8'hF0, 4'b0010},
    {4'b0000, 1'b0, 2'b00, 8'h00, 8'h55, 8'h00, 4'b0001},
    {4'b1001, 1'b0, 2'b00, 8'hFF, 8'hFF, 8'h00, 4'b0001},
    {4'b0010, 1'b1, 2'b01, 8'h00, 8'h81, 8'h40, 4'b0000},
    {4'b0010, 1'b1, 2'b10, 8'hFF, 8'h81, 8'h02, 4'b0000},
    {4'b0010, 1'b1, 2'b00, 8'h00, 8'h81, 8'h81, 4'b0010},
    {4'b0010, 1'b1, 2'b11, 8'h01, 8'h00, 8'h00, 4'b0001}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_reg(input logic [1:0] idx, input logic [W-1:0] val);
    wb_sel  = 1'b1;
    ext_din = val;
    dst_sel = idx;
    ld_en   = 1'b1;
    tick();
    ld_en   = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] idx, output logic [W-1:0] val);
    a_sel = idx;
    #1;
    val = addr_out;
  endtask

  task automatic idle_inputs();
    ld_en = 1'b0; dst_sel = 2'd0; a_sel = 2'd0; b_sel = 2'd0;
    cb_sel = 1'b0; const_in = '0; alu_op = 4'b0000; sh_op = 2'b00;
    fu_sel = 1'b0; wb_sel = 1'b0; ext_din = '0;
  endtask

  initial begin
    logic [W-1:0] rd;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1: registers clear after reset
    for (int k = 0; k < 4; k++) begin
      read_reg(2'(k), rd);
      check("R1", "reset value", 32'(rd), 32'h0);
    end

    // Table walk: R4, R5, R6, R7, R10
    for (int i = 0; i < NVEC; i++) begin
      logic [34:0] v;
      string tag;
      v = VEC[i];
      tag = v[30] ? "R6" : (v[34] ? "R10" : "R4");
      load_reg(2'd1, v[27:20]);
      load_reg(2'd2, v[19:12]);
      a_sel = 2'd1; b_sel = 2'd2; cb_sel = 1'b0;
      alu_op = v[34:31]; fu_sel = v[30]; sh_op = v[29:28];
      wb_sel = 1'b0; dst_sel = 2'd3; ld_en = 1'b1;
      #1;
      check("R5", $sformatf("carry vec %0d", i),    32'(flag_c), 32'(v[3]));
      check("R5", $sformatf("overflow vec %0d", i), 32'(flag_v), 32'(v[2]));
      check("R7", $sformatf("negative vec %0d", i), 32'(flag_n), 32'(v[1]));
      check("R7", $sformatf("zero vec %0d", i),     32'(flag_z), 32'(v[0]));
      tick();
      ld_en = 1'b0;
      read_reg(2'd3, rd);
      check(tag, $sformatf("result vec %0d", i), 32'(rd), 32'(v[11:4]));
    end

    // R9: single-edge R0 := R1 + R2
    load_reg(2'd0, 8'h99);
    load_reg(2'd1, 8'h21);
    load_reg(2'd2, 8'h13);
    load_reg(2'd3, 8'h77);
    a_sel = 2'b01; b_sel = 2'b10; cb_sel = 1'b0; alu_op = 4'b0010;
    fu_sel = 1'b0; wb_sel = 1'b0; dst_sel = 2'b00; ld_en = 1'b1;
    tick();
    ld_en = 1'b0;
    read_reg(2'd0, rd); check("R9", "R0 after one edge", 32'(rd), 32'h34);
    read_reg(2'd1, rd); check("R2", "R1 untouched", 32'(rd), 32'h21);
    read_reg(2'd3, rd); check("R2", "R3 untouched", 32'(rd), 32'h77);

    // R2: load enable low blocks the write
    wb_sel = 1'b1; ext_din = 8'hEE; dst_sel = 2'd0; ld_en = 1'b0;
    tick();
    read_reg(2'd0, rd); check("R2", "no load when disabled", 32'(rd), 32'h34);

    // R3: bus outputs and constant injection
    a_sel = 2'd1; b_sel = 2'd3; cb_sel = 1'b0; #1;
    check("R3", "addr_out bus A", 32'(addr_out), 32'h21);
    check("R3", "data_out register", 32'(data_out), 32'h77);
    cb_sel = 1'b1; const_in = 8'h5A; #1;
    check("R3", "data_out constant", 32'(data_out), 32'h5A);
    alu_op = 4'b0010; fu_sel = 1'b0; wb_sel = 1'b0; dst_sel = 2'd2; ld_en = 1'b1;
    tick();
    ld_en = 1'b0; cb_sel = 1'b0;
    read_reg(2'd2, rd); check("R3", "A plus constant", 32'(rd), 32'h7B);

    // R8: external data wins over function result
    a_sel = 2'd1; b_sel = 2'd2; alu_op = 4'b0010; fu_sel = 1'b0;
    wb_sel = 1'b1; ext_din = 8'hC3; dst_sel = 2'd1; ld_en = 1'b1;
    tick();
    ld_en = 1'b0;
    read_reg(2'd1, rd); check("R8", "external write-back", 32'(rd), 32'hC3);

    // R1: reset in mid-run clears loaded registers
    rst_n = 1'b0;
    #1;
    read_reg(2'd1, rd); check("R1", "async clear R1", 32'(rd), 32'h0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    for (int k = 0; k < 4; k++) begin
      read_reg(2'(k), rd);
      check("R1", "cleared after mid-run reset", 32'(rd), 32'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule